// File: doc/BRIEF.md
# Key Matrix Scanner with Frame Snapshot Readout

This block scans a matrix of six source lines by four return lines. A display scan generator supplies two signals: a window strobe that marks the key slot of each display frame, and a one-cycle pulse at the end of each frame. During the window the block drives the sources one at a time. Each source gets its own sub-slot of a fixed number of cycles. The four return inputs are sampled in the last cycle of each sub-slot. The samples collect in a working buffer. That buffer is copied into a snapshot only at the frame-end pulse, so software never sees a frame that is half updated.

A serial interface reads the snapshot through a byte handshake. A start pulse copies the snapshot into a shadow register and rewinds to the first byte. Each request then returns one byte on the next cycle. Every byte packs two sources, and reading past the third byte wraps to the first. Scanning runs only after a run command and stops on a halt command. While it is stopped, the sources stay low and the snapshot is held.

Top module: `key_matrix_scanner`

## Requirements
- R1: After reset, every source output is 0, `rd_valid` is 0, scanning is stopped and the snapshot reads as all zeros.
- R2: A `scan_halt` pulse stops scanning and wins over a `scan_run_set` pulse in the same cycle. A `scan_run_set` pulse alone starts scanning. While scanning is stopped, all source outputs are 0 and `frame_end` leaves the snapshot unchanged.
- R3: While scanning runs and `key_slot` is high, `src_drv` is one-hot. Bit 0 (first source) through bit 5 (sixth source) are driven in order, each for SUB_CYCLES cycles, starting in the first cycle of the slot. After the sixth source nothing is driven until `key_slot` falls. A low `key_slot` restarts the sequence at bit 0.
- R4: The returns are sampled in the last cycle of each sub-slot. `ret_in` bit 0 is the first return line. Samples are stored per source in a working buffer.
- R5: The snapshot takes the working buffer only on a `frame_end` cycle while scanning runs. Samples taken in a frame with no `frame_end` are not visible to a read.
- R6: Byte k (k = 0, 1, 2) carries source 2k+1 in bits 3:0 and source 2k+2 in bits 7:4. Within a nibble, return line 1 sits at the lowest bit.
- R7: `rd_start` copies the snapshot value that stands before that clock edge into the shadow register and selects byte 0. Each following `rd_req` delivers bytes in the order 0, 1, 2, 0, 1 and so on.
- R8: Bytes delivered after a `rd_start` come from the shadow register, even when a `frame_end` falls between requests.
- R9: A `rd_req` in the same cycle as `rd_start` is dropped: no `rd_valid` follows it and the byte pointer stays at 0.
- R10: `rd_valid` is high in exactly the cycle after each accepted `rd_req`, with `rd_byte` valid in that cycle. Back-to-back requests give one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_run_set | input | 1 | Pulse: start or resume scanning |
| scan_halt | input | 1 | Pulse: stop scanning (mode change) |
| key_slot | input | 1 | High during the key-scan window of a frame |
| frame_end | input | 1 | One-cycle pulse at the end of a display frame |
| ret_in | input | 4 | Return lines of the matrix |
| src_drv | output | 6 | One-hot source drive, active high |
| rd_start | input | 1 | Pulse: begin a read transfer |
| rd_req | input | 1 | Pulse: request the next byte |
| rd_valid | output | 1 | Byte on `rd_byte` is valid this cycle |
| rd_byte | output | 8 | Two packed sources, as in R6 |

## Verification
Two pairs of events can land in the same cycle and are provoked on purpose. The first pair is a frame-end latch and a read start. The bench pulses both together and expects the shadow register to hold the snapshot from before that edge. The newer frame then shows up only at the next read start. The second pair is a byte request and a read start, which the bench asserts together and for which it expects no valid byte. A reference model built from integer arrays follows every cycle and judges the source drive and every delivered byte against these rules.

// File: rtl/kms_pkg.sv
package kms_pkg;
    localparam int KMS_SOURCES    = 6;
    localparam int KMS_RETURNS    = 4;
    localparam int KMS_SUB_CYCLES = 4;
endpackage

// File: rtl/kms_sequencer.sv
module kms_sequencer #(
    parameter int NUM_SRC    = kms_pkg::KMS_SOURCES,
    parameter int SUB_CYCLES = kms_pkg::KMS_SUB_CYCLES,
    localparam int SRC_W     = $clog2(NUM_SRC + 1),
    localparam int CYC_W     = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_run_set,
    input  logic               scan_halt,
    input  logic               key_slot,
    output logic [NUM_SRC-1:0] src_drv_o,
    output logic               scan_run_o,
    output logic               sample_stb_o,
    output logic [SRC_W-1:0]   sample_idx_o
);
    typedef struct packed {
        logic             run;
        logic [SRC_W-1:0] src;
        logic [CYC_W-1:0] cyc;
    } seq_t;

    seq_t seq_d, seq_q;
    logic in_scan;
    logic last_cyc;

    always_comb begin
        in_scan  = seq_q.run && key_slot && (seq_q.src < SRC_W'(NUM_SRC));
        last_cyc = (seq_q.cyc == CYC_W'(SUB_CYCLES - 1));
        seq_d    = seq_q;
        if (scan_halt) begin
            seq_d.run = 1'b0;
        end else if (scan_run_set) begin
            seq_d.run = 1'b1;
        end
        if (!seq_q.run || !key_slot) begin
            seq_d.src = '0;
            seq_d.cyc = '0;
        end else if (seq_q.src < SRC_W'(NUM_SRC)) begin
            if (last_cyc) begin
                seq_d.cyc = '0;
                seq_d.src = seq_q.src + SRC_W'(1);
            end else begin
                seq_d.cyc = seq_q.cyc + CYC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign src_drv_o    = in_scan ? (NUM_SRC'(1) << seq_q.src) : '0;
    assign scan_run_o   = seq_q.run;
    assign sample_stb_o = in_scan && last_cyc;
    assign sample_idx_o = seq_q.src;

    AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_drv_o)); // R3
    AST_HALT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        scan_halt |=> (src_drv_o == '0)); // R2
    AST_SAMPLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |-> (sample_idx_o < SRC_W'(NUM_SRC))); // R4
endmodule

// File: rtl/kms_capture.sv
module kms_capture #(
    parameter int NUM_SRC = kms_pkg::KMS_SOURCES,
    parameter int NUM_RET = kms_pkg::KMS_RETURNS,
    localparam int SRC_W  = $clog2(NUM_SRC + 1),
    localparam int FLAT_W = NUM_SRC * NUM_RET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_stb,
    input  logic [SRC_W-1:0]   sample_idx,
    input  logic [NUM_RET-1:0] ret_in,
    input  logic               latch,
    output logic [FLAT_W-1:0]  snap_o
);
    typedef struct packed {
        logic [FLAT_W-1:0] work;
        logic [FLAT_W-1:0] snap;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (latch) begin
            cap_d.snap = cap_q.work;
        end
        if (sample_stb) begin
            cap_d.work[int'(sample_idx) * NUM_RET +: NUM_RET] = ret_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign snap_o = cap_q.snap;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(snap_o)); // R5
endmodule

// File: rtl/kms_reader.sv
module kms_reader #(
    parameter int NUM_SRC = kms_pkg::KMS_SOURCES,
    parameter int NUM_RET = kms_pkg::KMS_RETURNS,
    localparam int FLAT_W = NUM_SRC * NUM_RET,
    localparam int BYTE_W = 2 * NUM_RET,
    localparam int NBYTES = NUM_SRC / 2,
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAT_W-1:0] snap,
    input  logic              rd_start,
    input  logic              rd_req,
    output logic              rd_valid_o,
    output logic [BYTE_W-1:0] rd_byte_o
);
    typedef struct packed {
        logic [FLAT_W-1:0] shadow;
        logic [IDX_W-1:0]  idx;
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = 1'b0;
        if (rd_start) begin
            rd_d.shadow = snap;
            rd_d.idx    = '0;
        end else if (rd_req) begin
            rd_d.valid = 1'b1;
            rd_d.data  = rd_q.shadow[int'(rd_q.idx) * BYTE_W +: BYTE_W];
            if (rd_q.idx == IDX_W'(NBYTES - 1)) begin
                rd_d.idx = '0;
            end else begin
                rd_d.idx = rd_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o = rd_q.valid;
    assign rd_byte_o  = rd_q.data;

    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_start |=> $stable(rd_q.shadow)); // R8
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_start) |=> rd_valid_o); // R10
    AST_START_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_valid_o); // R9
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.idx < IDX_W'(NBYTES)); // R7
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner #(
    parameter int NUM_SRC    = kms_pkg::KMS_SOURCES,
    parameter int NUM_RET    = kms_pkg::KMS_RETURNS,
    parameter int SUB_CYCLES = kms_pkg::KMS_SUB_CYCLES,
    localparam int SRC_W     = $clog2(NUM_SRC + 1),
    localparam int FLAT_W    = NUM_SRC * NUM_RET,
    localparam int BYTE_W    = 2 * NUM_RET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_run_set,
    input  logic               scan_halt,
    input  logic               key_slot,
    input  logic               frame_end,
    input  logic [NUM_RET-1:0] ret_in,
    output logic [NUM_SRC-1:0] src_drv,
    input  logic               rd_start,
    input  logic               rd_req,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rd_byte
);
    logic              scan_run;
    logic              sample_stb;
    logic [SRC_W-1:0]  sample_idx;
    logic [FLAT_W-1:0] snap;

    kms_sequencer #(.NUM_SRC(NUM_SRC), .SUB_CYCLES(SUB_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_run_set (scan_run_set),
        .scan_halt    (scan_halt),
        .key_slot     (key_slot),
        .src_drv_o    (src_drv),
        .scan_run_o   (scan_run),
        .sample_stb_o (sample_stb),
        .sample_idx_o (sample_idx)
    );

    kms_capture #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .sample_idx (sample_idx),
        .ret_in     (ret_in),
        .latch      (frame_end && scan_run),
        .snap_o     (snap)
    );

    kms_reader #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap       (snap),
        .rd_start   (rd_start),
        .rd_req     (rd_req),
        .rd_valid_o (rd_valid),
        .rd_byte_o  (rd_byte)
    );

    AST_STOPPED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !key_slot |-> (src_drv == '0)); // R3
endmodule

// File: tb/key_matrix_scanner_test.sv
module key_matrix_scanner_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 6;
    localparam int SUB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_run_set = 1'b0, scan_halt = 1'b0, key_slot = 1'b0, frame_end = 1'b0;
    logic rd_start = 1'b0, rd_req = 1'b0;
    logic [3:0] ret_in = '0;
    logic [5:0] src_drv;
    logic       rd_valid;
    logic [7:0] rd_byte;

    key_matrix_scanner uut (
        .clk(clk), .rst_n(rst_n), .scan_run_set(scan_run_set), .scan_halt(scan_halt),
        .key_slot(key_slot), .frame_end(frame_end), .ret_in(ret_in), .src_drv(src_drv),
        .rd_start(rd_start), .rd_req(rd_req), .rd_valid(rd_valid), .rd_byte(rd_byte)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int compared = 0, mismatched = 0;
    bit finished = 0;
    string phase = "R1";

    // next-cycle stimulus, applied at the falling edge
    bit n_run = 0, n_halt = 0, n_slot = 0, n_fe = 0, n_rs = 0, n_rr = 0;
    int keys[NS];

    // reference model state
    int m_run = 0, m_src = 0, m_cyc = 0, m_idx = 0, m_valid = 0, m_byte = 0;
    int m_work[NS], m_snap[NS], m_shadow[NS];

    task automatic check(string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic cycle();
        int exp_drv;
        int r;
        @(negedge clk);
        scan_run_set = n_run; scan_halt = n_halt; key_slot = n_slot;
        frame_end = n_fe; rd_start = n_rs; rd_req = n_rr;
        exp_drv = (m_run != 0 && n_slot && m_src < NS) ? (1 << m_src) : 0;
        r = (exp_drv != 0) ? keys[m_src] : 0;
        ret_in = 4'(r);
        #1;
        if (rst_n) begin
            check("R3 src_drv", int'(src_drv), exp_drv);
            check("R10 rd_valid", int'(rd_valid), m_valid);
            if (m_valid != 0) check("R6 rd_byte", int'(rd_byte), m_byte);
        end
        // reader (uses snapshot before this edge)
        m_valid = 0;
        if (n_rs) begin
            for (int i = 0; i < NS; i++) m_shadow[i] = m_snap[i];
            m_idx = 0;
        end else if (n_rr) begin
            m_valid = 1;
            m_byte  = m_shadow[2*m_idx] | (m_shadow[2*m_idx+1] << 4);
            m_idx   = (m_idx + 1) % (NS / 2);
        end
        if (n_fe && m_run != 0)
            for (int i = 0; i < NS; i++) m_snap[i] = m_work[i];
        if (exp_drv != 0 && m_cyc == SUB - 1) m_work[m_src] = r;
        if (m_run == 0 || !n_slot) begin
            m_src = 0; m_cyc = 0;
        end else if (m_src < NS) begin
            if (m_cyc == SUB - 1) begin m_cyc = 0; m_src++; end
            else m_cyc++;
        end
        if (n_halt) m_run = 0;
        else if (n_run) m_run = 1;
    endtask

    task automatic pulse_run();  n_run = 1;  cycle(); n_run = 0;  endtask
    task automatic pulse_halt(); n_halt = 1; cycle(); n_halt = 0; endtask

    task automatic frame(bit do_end, int slot_len);
        n_slot = 1; repeat (slot_len) cycle(); n_slot = 0;
        cycle(); cycle();
        n_fe = do_end; cycle(); n_fe = 0; cycle();
    endtask

    task automatic reqs(int n);
        for (int i = 0; i < n; i++) begin n_rr = 1; cycle(); n_rr = 0; cycle(); end
    endtask

    task automatic read(int n);
        n_rs = 1; cycle(); n_rs = 0; reqs(n); cycle();
    endtask

    task automatic set_keys(int a, int b, int c, int d, int e, int f);
        keys[0] = a; keys[1] = b; keys[2] = c; keys[3] = d; keys[4] = e; keys[5] = f;
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin m_work[i] = 0; m_snap[i] = 0; m_shadow[i] = 0; end
        set_keys(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1"; // reset state: no drive, no valid, zero snapshot
        check("R1 src_drv", int'(src_drv), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        read(3);
        phase = "R2"; // stopped: no drive, frame_end ignored
        set_keys(15, 15, 15, 15, 15, 15);
        frame(1, NS*SUB + 2);
        read(3);
        phase = "R4"; // scan, sample, latch, byte packing R6, wrap R7
        pulse_run();
        set_keys(1, 2, 4, 8, 3, 12);
        frame(1, NS*SUB + 2);
        phase = "R7";
        read(4);
        phase = "R5"; // frame without end: snapshot unchanged
        set_keys(15, 0, 5, 10, 6, 9);
        frame(0, NS*SUB + 2);
        read(3);
        phase = "R3"; // short slot, then restart from first source
        set_keys(7, 11, 13, 14, 1, 0);
        frame(0, 10);
        frame(1, NS*SUB + 3);
        phase = "R8"; // latch between requests does not tear the transfer
        n_rs = 1; cycle(); n_rs = 0; reqs(1);
        set_keys(9, 6, 3, 12, 5, 10);
        frame(1, NS*SUB + 2);
        reqs(3);
        phase = "R7"; // rd_start together with frame_end: old snapshot captured
        set_keys(2, 4, 6, 8, 10, 12);
        n_slot = 1; repeat (NS*SUB + 2) cycle(); n_slot = 0; cycle();
        n_fe = 1; n_rs = 1; cycle(); n_fe = 0; n_rs = 0;
        reqs(3);
        read(3);
        phase = "R9"; // request with rd_start is dropped
        n_rs = 1; n_rr = 1; cycle(); n_rs = 0; n_rr = 0; cycle();
        reqs(2);
        phase = "R10"; // back-to-back requests
        n_rs = 1; cycle(); n_rs = 0;
        n_rr = 1; repeat (4) cycle(); n_rr = 0; cycle(); cycle();
        phase = "R2"; // halt wins over run in same cycle
        n_halt = 1; n_run = 1; cycle(); n_halt = 0; n_run = 0;
        set_keys(9, 9, 6, 6, 15, 15);
        frame(1, NS*SUB + 2);
        read(3);
        pulse_run();
        frame(1, NS*SUB + 2);
        read(3);
        pulse_halt();
        frame(1, NS*SUB + 2);
        read(3);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule